// File: doc/BRIEF.md
# Delay Line Configuration Sequencer

This block sequences the control bits of a programmable delay line that shifts the sampling clock of a storage-card host interface. It takes one command at a time. An init command resets the line, brings it back up in a fixed order, loads a frequency band code chosen from the current interface clock rate, and waits for the line to report lock. A set-phase command moves the sampling point to one of sixteen steps. It stops the delayed clock output, writes the step as a Gray code, restarts the output, and then gives tracking back to the line's own clock-data recovery.

Every control change is a separate registered step, so each bit change reaches the line in its own clock cycle and in the required order. Each wait for a status input is bounded by a cycle limit the caller programs. When a wait expires, an error flag is raised and the sequencer returns to idle. A one-cycle done pulse marks successful completion. A busy output tells the caller when a new command would be ignored.

Top module: `dlseq_top`

## Requirements
- R1: After reset, every line control output, the frequency code, the phase code, busy, done and err are all 0.
- R2: An init command (cmd_op = 0) makes these changes on the line outputs in this order, each in its own cycle: power-save cleared, reset set, power-down set, frequency code loaded, reset cleared, power-down cleared, enable set, clock-output-enable set. A step that would not change a value produces no change.
- R3: The frequency code is taken from rate_mhz when the command is accepted. It is 0 for rates up to 112. It is 1, 2, 3, 4, 5 or 6 for rates up to 125, 137, 150, 162, 175 or 187. It is 7 for any higher rate.
- R4: Init finishes only after lock_in has been seen high following the clock-output-enable step.
- R5: While idle, line_pwrsave follows pwrsave_en. During init it is held at 0 from the first step until lock. On completion it returns to the value it had when init started.
- R6: A set-phase command (cmd_op = 1) leaves line_gray equal to cmd_phase XOR (cmd_phase >> 1). For indices 0 to 15 this gives 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8.
- R7: The first step of set-phase is one single change: CDR-enable = 0, clock-output-enable = 0, external-CDR-enable = 1, enable = 1. CDR-enable and external-CDR-enable are never both 1.
- R8: The phase code changes only after oe_fb has been seen at 0, and only while clock-output-enable is 0 and was 0 in the previous cycle.
- R9: After the phase code is written, clock-output-enable is set. Once oe_fb reads 1, CDR-enable is set and external-CDR-enable is cleared in the same cycle as done.
- R10: If a wait condition is not met within wait_limit + 1 cycles, err goes to 1, busy drops, done does not pulse, and the line outputs keep their values. err clears when the next command is accepted.
- R11: busy is high from the cycle after a command is accepted until the sequencer is idle again. A command presented while busy has no effect.
- R12: done is a single-cycle pulse, and busy is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 1 | 0 = init, 1 = set-phase |
| cmd_phase | input | 4 | Phase step index for set-phase |
| rate_mhz | input | RATE_W | Current interface clock rate in MHz |
| wait_limit | input | TO_W | Timeout limit for every wait state, in cycles |
| pwrsave_en | input | 1 | Requested power-save setting |
| lock_in | input | 1 | Lock status from the delay line |
| oe_fb | input | 1 | Clock-output-enable feedback from the delay line |
| line_pwrsave | output | 1 | Power-save bit to the line |
| line_rst | output | 1 | Reset bit to the line |
| line_pdn | output | 1 | Power-down bit to the line |
| line_en | output | 1 | Enable bit to the line |
| line_clkout_en | output | 1 | Clock-output-enable bit |
| line_cdr_en | output | 1 | CDR-enable bit |
| line_cdr_ext_en | output | 1 | External-CDR-enable bit |
| line_freq | output | 3 | Frequency band code |
| line_gray | output | 4 | Gray-coded phase step |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout flag |

## Verification
The assertions assume that rate_mhz, wait_limit and pwrsave_en stay stable while a command runs. They also assume that oe_fb follows line_clkout_en, with delay, and does not toggle on its own, and that lock_in does not drop during the final init step. The bench feeds oe_fb from a two-stage copy of clock-output-enable and derives lock_in from a counter that restarts whenever reset, power-down or disable is applied. It forces either input to a fixed level only to provoke timeouts. It changes pwrsave_en only between commands.

// File: rtl/dlseq_pkg.sv
package dlseq_pkg;

    localparam int FREQ_W     = 3;
    localparam int PHASE_W    = 4;
    localparam int NUM_BOUNDS = (1 << FREQ_W) - 1;
    // upper edge (MHz) of each band except the last
    localparam int unsigned BAND_TOP_MHZ [NUM_BOUNDS] = '{112, 125, 137, 150, 162, 175, 187};

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_I_SAVE,
        ST_I_RST,
        ST_I_PDN,
        ST_I_FREQ,
        ST_I_RCLR,
        ST_I_PCLR,
        ST_I_EN,
        ST_I_CLK,
        ST_I_LOCK,
        ST_I_REST,
        ST_P_STEP1,
        ST_P_WOFF,
        ST_P_GRAY,
        ST_P_CLK,
        ST_P_WON,
        ST_P_CDR
    } seq_state_e;

    typedef struct packed {
        logic               ps;
        logic               rst;
        logic               pdn;
        logic               en;
        logic               clkout;
        logic               cdr;
        logic               ext;
        logic [FREQ_W-1:0]  freq;
        logic [PHASE_W-1:0] gray;
    } line_ctl_t;

endpackage

// File: rtl/dlseq_freq_sel.sv
module dlseq_freq_sel
    import dlseq_pkg::*;
#(
    parameter int RATE_W = 8
) (
    input  logic [RATE_W-1:0] rate_mhz,
    output logic [FREQ_W-1:0] code
);

    logic [NUM_BOUNDS-1:0] above;

    for (genvar k = 0; k < NUM_BOUNDS; k++) begin : g_band
        assign above[k] = (rate_mhz > RATE_W'(BAND_TOP_MHZ[k]));
    end

    // thermometer count; above the last listed edge it saturates at the top code
    assign code = FREQ_W'($countones(above));

endmodule

// File: rtl/dlseq_gray_enc.sv
module dlseq_gray_enc #(
    parameter int W = 4
) (
    input  logic [W-1:0] bin,
    output logic [W-1:0] gray
);

    assign gray[W-1] = bin[W-1];
    for (genvar i = 0; i < W - 1; i++) begin : g_bit
        assign gray[i] = bin[i] ^ bin[i+1];
    end

endmodule

// File: rtl/dlseq_wait_timer.sv
module dlseq_wait_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_wait,
    input  logic            met,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);

    logic [TO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!in_wait || met) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = in_wait && !met && (cnt_q == limit);

    // R10: the count never passes the limit while waiting (limit held stable)
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && $stable(limit) |-> cnt_q <= limit);

endmodule

// File: rtl/dlseq_top.sv
module dlseq_top
    import dlseq_pkg::*;
#(
    parameter int RATE_W = 8,
    parameter int TO_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_op,
    input  logic [PHASE_W-1:0] cmd_phase,
    input  logic [RATE_W-1:0]  rate_mhz,
    input  logic [TO_W-1:0]    wait_limit,
    input  logic               pwrsave_en,
    input  logic               lock_in,
    input  logic               oe_fb,
    output logic               line_pwrsave,
    output logic               line_rst,
    output logic               line_pdn,
    output logic               line_en,
    output logic               line_clkout_en,
    output logic               line_cdr_en,
    output logic               line_cdr_ext_en,
    output logic [FREQ_W-1:0]  line_freq,
    output logic [PHASE_W-1:0] line_gray,
    output logic               busy,
    output logic               done,
    output logic               err
);

    typedef struct packed {
        seq_state_e         st;
        line_ctl_t          ctl;
        logic               saved_ps;
        logic [FREQ_W-1:0]  pend_freq;
        logic [PHASE_W-1:0] pend_gray;
        logic               done;
        logic               err;
    } seq_regs_t;

    seq_regs_t d, q;

    logic [FREQ_W-1:0]  freq_code;
    logic [PHASE_W-1:0] gray_code;
    logic               in_wait, wait_met, wait_expired;

    dlseq_freq_sel #(.RATE_W(RATE_W)) u_freq (
        .rate_mhz (rate_mhz),
        .code     (freq_code)
    );

    dlseq_gray_enc #(.W(PHASE_W)) u_gray (
        .bin  (cmd_phase),
        .gray (gray_code)
    );

    always_comb begin
        unique case (q.st)
            ST_I_LOCK: begin in_wait = 1'b1; wait_met = lock_in;  end
            ST_P_WOFF: begin in_wait = 1'b1; wait_met = !oe_fb;   end
            ST_P_WON:  begin in_wait = 1'b1; wait_met = oe_fb;    end
            default:   begin in_wait = 1'b0; wait_met = 1'b0;     end
        endcase
    end

    dlseq_wait_timer #(.TO_W(TO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_wait (in_wait),
        .met     (wait_met),
        .limit   (wait_limit),
        .expired (wait_expired)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.ctl.ps = pwrsave_en;
                if (cmd_valid) begin
                    d.err       = 1'b0;
                    d.pend_freq = freq_code;
                    d.pend_gray = gray_code;
                    d.st        = cmd_op ? ST_P_STEP1 : ST_I_SAVE;
                end
            end
            ST_I_SAVE: begin
                d.saved_ps = q.ctl.ps;
                d.ctl.ps   = 1'b0;
                d.st       = ST_I_RST;
            end
            ST_I_RST:  begin d.ctl.rst    = 1'b1;        d.st = ST_I_PDN;  end
            ST_I_PDN:  begin d.ctl.pdn    = 1'b1;        d.st = ST_I_FREQ; end
            ST_I_FREQ: begin d.ctl.freq   = q.pend_freq; d.st = ST_I_RCLR; end
            ST_I_RCLR: begin d.ctl.rst    = 1'b0;        d.st = ST_I_PCLR; end
            ST_I_PCLR: begin d.ctl.pdn    = 1'b0;        d.st = ST_I_EN;   end
            ST_I_EN:   begin d.ctl.en     = 1'b1;        d.st = ST_I_CLK;  end
            ST_I_CLK:  begin d.ctl.clkout = 1'b1;        d.st = ST_I_LOCK; end
            ST_I_LOCK: begin
                if (wait_met) begin
                    d.st = ST_I_REST;
                end else if (wait_expired) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_I_REST: begin
                d.ctl.ps = q.saved_ps;
                d.done   = 1'b1;
                d.st     = ST_IDLE;
            end
            ST_P_STEP1: begin
                d.ctl.cdr    = 1'b0;
                d.ctl.clkout = 1'b0;
                d.ctl.ext    = 1'b1;
                d.ctl.en     = 1'b1;
                d.st         = ST_P_WOFF;
            end
            ST_P_WOFF: begin
                if (wait_met) begin
                    d.st = ST_P_GRAY;
                end else if (wait_expired) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_P_GRAY: begin d.ctl.gray   = q.pend_gray; d.st = ST_P_CLK; end
            ST_P_CLK:  begin d.ctl.clkout = 1'b1;        d.st = ST_P_WON; end
            ST_P_WON: begin
                if (wait_met) begin
                    d.st = ST_P_CDR;
                end else if (wait_expired) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_P_CDR: begin
                d.ctl.cdr = 1'b1;
                d.ctl.ext = 1'b0;
                d.done    = 1'b1;
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ctl: '0, saved_ps: 1'b0, pend_freq: '0,
                   pend_gray: '0, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign line_pwrsave    = q.ctl.ps;
    assign line_rst        = q.ctl.rst;
    assign line_pdn        = q.ctl.pdn;
    assign line_en         = q.ctl.en;
    assign line_clkout_en  = q.ctl.clkout;
    assign line_cdr_en     = q.ctl.cdr;
    assign line_cdr_ext_en = q.ctl.ext;
    assign line_freq       = q.ctl.freq;
    assign line_gray       = q.ctl.gray;
    assign busy            = (q.st != ST_IDLE);
    assign done            = q.done;
    assign err             = q.err;

    // R2: bring-up ordering between reset, power-down, enable and output enable
    assert_pdn_after_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_pdn) |-> line_rst);
    assert_rst_clr_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_pdn) |-> !line_rst);
    assert_clkout_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_clkout_en) |-> line_en && !line_rst && !line_pdn);

    // R4: completion of init follows an observed lock
    assert_lock_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_I_REST) |-> $past(lock_in));

    // R5: power-save held low through the bring-up
    assert_ps_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st inside {ST_I_RST, ST_I_PDN, ST_I_FREQ, ST_I_RCLR, ST_I_PCLR,
                      ST_I_EN, ST_I_CLK, ST_I_LOCK}) |-> !line_pwrsave);

    // R7: internal and external recovery never enabled together
    assert_cdr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_cdr_en && line_cdr_ext_en));

    // R8: phase code moves only with the output clock gated
    assert_gray_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_gray) |-> !line_clkout_en && !$past(line_clkout_en));

    // R9: recovery handed back with output running, at completion
    assert_cdr_handback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_cdr_en) |-> line_clkout_en && done);

    // R10: timeout leaves the sequencer idle
    assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy && !done);

    // R12: done is a lone pulse raised in idle
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/tb_dlseq_top.sv
module tb_dlseq_top;

    localparam int B_PS = 13, B_RST = 12, B_PDN = 11, B_EN = 10, B_CLK = 9, B_CDR = 8, B_EXT = 7;
    localparam int LIMIT = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid, cmd_op, pwrsave_en, lock_in, oe_fb;
    logic [3:0] cmd_phase;
    logic [7:0] rate_mhz;
    logic [15:0] wait_limit;
    logic       line_pwrsave, line_rst, line_pdn, line_en, line_clkout_en;
    logic       line_cdr_en, line_cdr_ext_en, busy, done, err;
    logic [2:0] line_freq;
    logic [3:0] line_gray;

    always #10 clk = ~clk;

    dlseq_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_phase(cmd_phase), .rate_mhz(rate_mhz), .wait_limit(wait_limit),
        .pwrsave_en(pwrsave_en), .lock_in(lock_in), .oe_fb(oe_fb),
        .line_pwrsave(line_pwrsave), .line_rst(line_rst), .line_pdn(line_pdn),
        .line_en(line_en), .line_clkout_en(line_clkout_en), .line_cdr_en(line_cdr_en),
        .line_cdr_ext_en(line_cdr_ext_en), .line_freq(line_freq), .line_gray(line_gray),
        .busy(busy), .done(done), .err(err)
    );

    // delay line model: feedback trails output enable; lock after settling
    logic [1:0] fb_pipe;
    int         fb_mode;      // 0 follow, 1 stuck high, 2 stuck low
    logic [2:0] lk_cnt;
    logic       lock_block;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_pipe <= '0;
            lk_cnt  <= '0;
        end else begin
            fb_pipe <= {fb_pipe[0], line_clkout_en};
            if (line_rst || line_pdn || !line_en) lk_cnt <= '0;
            else if (lk_cnt < 3'd5) lk_cnt <= lk_cnt + 3'd1;
        end
    end
    assign oe_fb   = (fb_mode == 1) ? 1'b1 : (fb_mode == 2) ? 1'b0 : fb_pipe[1];
    assign lock_in = (lk_cnt == 3'd5) && !lock_block;

    int n_tests = 0, n_fail = 0;
    logic [13:0] exp_q[$];
    logic [13:0] model, prev;
    bit          mon_on = 0;
    string       mon_req = "R2";
    logic [3:0]  gtab [16] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7, 4'h5, 4'h4,
                               4'hC, 4'hD, 4'hF, 4'hE, 4'hA, 4'hB, 4'h9, 4'h8};

    function automatic logic [13:0] obs();
        return {line_pwrsave, line_rst, line_pdn, line_en, line_clkout_en,
                line_cdr_en, line_cdr_ext_en, line_freq, line_gray};
    endfunction

    function automatic logic [2:0] exp_freq(input int r);
        if (r <= 112) return 3'd0;
        else if (r <= 125) return 3'd1;
        else if (r <= 137) return 3'd2;
        else if (r <= 150) return 3'd3;
        else if (r <= 162) return 3'd4;
        else if (r <= 175) return 3'd5;
        else if (r <= 187) return 3'd6;
        else return 3'd7;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [13:0] nv);
        if (nv != model) begin
            exp_q.push_back(nv);
            model = nv;
        end
    endtask

    // scoreboard monitor: every change of the line controls must match the next expected item
    always @(negedge clk) begin
        if (mon_on) begin
            logic [13:0] cur;
            cur = obs();
            if (cur != prev) begin
                if (exp_q.size() == 0) begin
                    check(0, "R11", "unexpected line change", 32'(cur), 32'(prev));
                end else begin
                    logic [13:0] e;
                    e = exp_q.pop_front();
                    check(cur == e, mon_req, "ordered line change", 32'(cur), 32'(e));
                end
                prev = cur;
            end
        end
    end

    task automatic send(input logic op, input logic [3:0] ph, input int rate);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_phase = ph; rate_mhz = 8'(rate);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push_init_front(input int rate);
        logic [13:0] m;
        m = model; m[B_PS] = 1'b0;  push(m);
        m[B_RST] = 1'b1;            push(m);
        m[B_PDN] = 1'b1;            push(m);
        m[6:4]   = exp_freq(rate);  push(m);
        m[B_RST] = 1'b0;            push(m);
        m[B_PDN] = 1'b0;            push(m);
        m[B_EN]  = 1'b1;            push(m);
        m[B_CLK] = 1'b1;            push(m);
    endtask

    task automatic wait_done(input string req);
        bit seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
        check(seen, req, "done seen", 32'(seen), 32'd1);
        check(!busy, "R12", "busy low with done", 32'(busy), 32'd0);
        check(!err, "R10", "err clear after success", 32'(err), 32'd0);
        @(negedge clk);
        check(!done, "R12", "done lasts one cycle", 32'(done), 32'd0);
        check(exp_q.size() == 0, req, "all expected steps seen", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic wait_timeout(input string req);
        bit saw_done = 0;
        bit idle = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done) saw_done = 1;
            if (!busy) begin idle = 1; break; end
        end
        check(idle, "R10", "idle after timeout", 32'(idle), 32'd1);
        check(err, "R10", "err raised on timeout", 32'(err), 32'd1);
        check(!saw_done, "R10", "no done on timeout", 32'(saw_done), 32'd0);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, req, "steps before timeout seen", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic do_init(input int rate);
        logic [13:0] m;
        logic        ps0;
        ps0 = model[B_PS];
        mon_req = "R2";
        send(1'b0, 4'h0, rate);
        check(busy, "R11", "busy after accept", 32'(busy), 32'd1);
        push_init_front(rate);
        m = model; m[B_PS] = ps0; push(m);
        wait_done("R4");
        check(line_freq == exp_freq(rate), "R3", "frequency code", 32'(line_freq), 32'(exp_freq(rate)));
        check(line_pwrsave == ps0, "R5", "power-save restored", 32'(line_pwrsave), 32'(ps0));
        check(lock_in, "R4", "lock present at completion", 32'(lock_in), 32'd1);
    endtask

    task automatic do_phase(input int idx);
        logic [13:0] m;
        mon_req = "R7";
        send(1'b1, 4'(idx), 0);
        m = model; m[B_CDR] = 1'b0; m[B_CLK] = 1'b0; m[B_EXT] = 1'b1; m[B_EN] = 1'b1; push(m);
        m[3:0] = gtab[idx];  push(m);
        m[B_CLK] = 1'b1;     push(m);
        m[B_CDR] = 1'b1; m[B_EXT] = 1'b0; push(m);
        wait_done("R9");
        check(line_gray == gtab[idx], "R6", "gray code of phase", 32'(line_gray), 32'(gtab[idx]));
        check(line_cdr_en && !line_cdr_ext_en, "R9", "recovery handed back",
              32'({line_cdr_en, line_cdr_ext_en}), 32'b10);
    endtask

    task automatic set_pwrsave(input logic v);
        logic [13:0] m;
        mon_req = "R5";
        m = model; m[B_PS] = v; push(m);
        @(negedge clk);
        pwrsave_en = v;
        repeat (2) @(negedge clk);
        check(line_pwrsave == v, "R5", "power-save follows input when idle", 32'(line_pwrsave), 32'(v));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [13:0] m;
        int rates [12] = '{112, 113, 125, 126, 137, 138, 187, 188, 200, 201, 255, 0};
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 1'b0; cmd_phase = '0; rate_mhz = '0;
        wait_limit = 16'(LIMIT); pwrsave_en = 1'b0; fb_mode = 0; lock_block = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(obs() == 14'd0, "R1", "line outputs after reset", 32'(obs()), 32'd0);
        check({busy, done, err} == 3'b000, "R1", "status after reset", 32'({busy, done, err}), 32'd0);
        model = '0; prev = '0; mon_on = 1;

        set_pwrsave(1'b1);
        do_init(150);

        for (int i = 0; i < 12; i++) do_init(rates[i]);

        for (int i = 0; i < 16; i++) do_phase(i);
        do_phase(5);

        set_pwrsave(1'b0);
        do_init(100);

        // R11: a set-phase command during init is ignored
        mon_req = "R11";
        send(1'b0, 4'h0, 170);
        push_init_front(170);
        m = model; push(m);
        repeat (2) @(negedge clk);
        check(busy, "R11", "busy during init", 32'(busy), 32'd1);
        send(1'b1, 4'hB, 0);
        wait_done("R11");
        check(line_gray == model[3:0], "R11", "phase unchanged by ignored command",
              32'(line_gray), 32'(model[3:0]));

        // R10: init times out when lock never arrives
        set_pwrsave(1'b1);
        lock_block = 1'b1;
        mon_req = "R10";
        send(1'b0, 4'h0, 130);
        push_init_front(130);
        m = model; m[B_PS] = 1'b1; push(m);
        wait_timeout("R10");
        lock_block = 1'b0;
        do_init(120);

        // R10: set-phase times out when feedback never drops
        fb_mode = 1;
        mon_req = "R10";
        send(1'b1, 4'h9, 0);
        m = model; m[B_CDR] = 1'b0; m[B_CLK] = 1'b0; m[B_EXT] = 1'b1; m[B_EN] = 1'b1; push(m);
        wait_timeout("R10");
        check(line_gray == model[3:0], "R8", "phase not written without feedback low",
              32'(line_gray), 32'(model[3:0]));
        fb_mode = 0;
        repeat (3) @(negedge clk);
        do_phase(9);

        // R10: set-phase times out when feedback never rises
        fb_mode = 2;
        mon_req = "R10";
        send(1'b1, 4'h3, 0);
        m = model; m[B_CDR] = 1'b0; m[B_CLK] = 1'b0; m[B_EXT] = 1'b1; m[B_EN] = 1'b1; push(m);
        m[3:0] = gtab[3]; push(m);
        m[B_CLK] = 1'b1;  push(m);
        wait_timeout("R10");
        check(!line_cdr_en && line_cdr_ext_en, "R10", "outputs held after timeout",
              32'({line_cdr_en, line_cdr_ext_en}), 32'b01);
        fb_mode = 0;
        repeat (3) @(negedge clk);
        do_phase(12);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule